// File: doc/BRIEF.md
# DRAM Bank Activation Timing Guard

This block sits between a memory command scheduler and the DRAM command bus. Each cycle the scheduler presents one proposed command (ACTIVATE, READ, WRITE, PRECHARGE or NOP) with a bank and row address. The guard answers in the same cycle whether that command may go out now. It keeps per-bank open/closed state and the open row, and it enforces the minimum command spacings. All timing limits arrive as static cycle counts on configuration inputs. The conversion from time to cycles is done outside the block: divide each limit by the clock period and round up to the next whole number.

A proposal that is allowed counts as issued, and it updates the tracked state on the next clock edge. A proposal that is refused changes nothing. In the cycle after a refusal, a one-cycle violation flag rises together with a code naming the broken rule. The scheduler can retry the command freely.

Top module: `act_timing_guard`

## Requirements
- R1: An ACTIVATE to a bank whose row is already open is refused with code 1.
- R2: An ACTIVATE to a bank whose previous ACTIVATE was fewer than `t_rc_i` cycles earlier is refused with code 2. Exactly `t_rc_i` cycles later it is allowed.
- R3: Two ACTIVATEs must be at least `t_rrd_i` cycles apart, whichever banks they name. A shorter gap is refused with code 3.
- R4: At most four ACTIVATEs may be issued in any window of `t_faw_i` cycles. A fifth is refused with code 4 until the oldest of the last four is at least `t_faw_i` cycles old.
- R5: A READ or WRITE to a bank with no open row is refused with code 5.
- R6: A READ or WRITE is allowed only when the cycles elapsed since its bank's ACTIVATE, plus `al_i`, reach at least `t_rcd_i`. Otherwise it is refused with code 6.
- R7: READ after READ, and WRITE after WRITE, must be at least `t_ccd_i` cycles apart, or the command is refused with code 7. A READ does not delay a WRITE, and a WRITE does not delay a READ.
- R8: PRECHARGE and NOP are always allowed. A PRECHARGE closes its bank from the next cycle. A PRECHARGE to a closed bank leaves every bank state unchanged.
- R9: A refused proposal raises `viol_o` for the following cycle with its code on `viol_code_o`. An allowed proposal gives `viol_o`=0 and code 0 in the following cycle. A refused proposal changes no tracked state.
- R10: After reset all banks are closed, `viol_o` is low, and every timer counts as long expired.
- R11: When several rules fail at once, the lowest code is reported. An open bank (1) outranks tRC (2), which outranks tRRD (3), which outranks tFAW (4). A closed bank (5) outranks tRCD (6), which outranks tCCD (7).
- R12: `open_row_o` shows the row most recently activated in the bank named by `bank_i`.
- R13: Command encoding on `cmd_i`: 0 = NOP, 1 = ACTIVATE, 2 = READ, 3 = WRITE, 4 = PRECHARGE. Codes 5 to 7 are treated as NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Proposed command (encoding in R13) |
| bank_i | input | BANK_W | Bank of the proposal |
| row_i | input | ROW_W | Row for ACTIVATE |
| t_rcd_i | input | CNT_W | ACTIVATE to READ/WRITE, cycles |
| t_rc_i | input | CNT_W | ACTIVATE to ACTIVATE, same bank, cycles |
| t_rrd_i | input | CNT_W | ACTIVATE to ACTIVATE, any bank, cycles |
| t_faw_i | input | CNT_W | Four-activate window, cycles |
| t_ccd_i | input | CNT_W | READ to READ / WRITE to WRITE, cycles |
| al_i | input | CNT_W | Additive latency, cycles |
| allow_o | output | 1 | Proposal may be issued this cycle |
| viol_o | output | 1 | Previous cycle's proposal was refused |
| viol_code_o | output | 3 | Rule broken by the previous proposal (0 when allowed) |
| bank_open_o | output | 2**BANK_W | Open flag per bank |
| open_row_o | output | ROW_W | Open row of bank `bank_i` |

## Verification
The bench builds the guard with its default parameters: 3 bank-address bits, 14-bit rows and 8-bit saturating timers. It drives the limits at small values (tRCD 5, tRC 12, tRRD 2, tFAW 10, tCCD 4, additive latency 0 and then 3). With these values every limit can be hit on its exact boundary cycle within a few dozen cycles. Four ACTIVATEs at the tRRD pace fill the window before tFAW expires, so the fifth is refused twice and then allowed. The largest row value and the highest bank are also used, to reach the edges of the address fields.

// File: rtl/act_guard_pkg.sv
package act_guard_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  // lower value wins when several rules fail
  typedef enum logic [2:0] {
    ERR_NONE   = 3'd0,
    ERR_OPEN   = 3'd1,
    ERR_RC     = 3'd2,
    ERR_RRD    = 3'd3,
    ERR_FAW    = 3'd4,
    ERR_CLOSED = 3'd5,
    ERR_RCD    = 3'd6,
    ERR_CCD    = 3'd7
  } err_e;
endpackage

// File: rtl/bank_tracker.sv
module bank_tracker #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int CNT_W  = 8,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             act_set_i,
  input  logic                             pre_set_i,
  input  logic [BANK_W-1:0]                bank_i,
  input  logic [ROW_W-1:0]                 row_i,
  output logic [NBANK-1:0]                 open_o,
  output logic [NBANK-1:0][ROW_W-1:0]      row_o,
  output logic [NBANK-1:0][CNT_W-1:0]      since_act_o
);
  logic [NBANK-1:0] open_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic sel;
    assign sel = (bank_i == BANK_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q[b]      <= 1'b0;
        row_o[b]       <= '0;
        since_act_o[b] <= '1;
      end else begin
        if (act_set_i && sel) begin
          open_q[b]      <= 1'b1;
          row_o[b]       <= row_i;
          since_act_o[b] <= CNT_W'(1);
        end else begin
          if (since_act_o[b] != '1) since_act_o[b] <= since_act_o[b] + 1'b1;
          if (pre_set_i && sel) open_q[b] <= 1'b0;
        end
      end
    end
  end

  assign open_o = open_q;

  p_act_opens_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_set_i |=> open_q[$past(bank_i)]);

  p_pre_closes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_set_i |=> !open_q[$past(bank_i)]);
endmodule

// File: rtl/act_window.sv
module act_window #(
  parameter int CNT_W = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic [CNT_W-1:0] t_faw_i,
  output logic [CNT_W-1:0] since_any_o,
  output logic             oldest_valid_o,
  output logic [CNT_W-1:0] oldest_age_o
);
  logic [DEPTH-1:0]            valid_q;
  logic [DEPTH-1:0][CNT_W-1:0] age_q;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q     <= '0;
      age_q       <= '1;
      since_any_o <= '1;
    end else if (act_i) begin
      valid_q[0]  <= 1'b1;
      age_q[0]    <= CNT_W'(1);
      since_any_o <= CNT_W'(1);
      for (int i = 1; i < DEPTH; i++) begin
        valid_q[i] <= valid_q[i-1];
        age_q[i]   <= sat_inc(age_q[i-1]);
      end
    end else begin
      since_any_o <= sat_inc(since_any_o);
      for (int i = 0; i < DEPTH; i++) age_q[i] <= sat_inc(age_q[i]);
    end
  end

  assign oldest_valid_o = valid_q[DEPTH-1];
  assign oldest_age_o   = age_q[DEPTH-1];

  p_faw_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && valid_q[DEPTH-1]) |-> (age_q[DEPTH-1] >= t_faw_i));
endmodule

// File: rtl/cas_spacing.sv
module cas_spacing #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] t_ccd_i,
  output logic [CNT_W-1:0] since_rd_o,
  output logic [CNT_W-1:0] since_wr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_rd_o <= '1;
      since_wr_o <= '1;
    end else begin
      if (rd_i)                   since_rd_o <= CNT_W'(1);
      else if (since_rd_o != '1)  since_rd_o <= since_rd_o + 1'b1;
      if (wr_i)                   since_wr_o <= CNT_W'(1);
      else if (since_wr_o != '1)  since_wr_o <= since_wr_o + 1'b1;
    end
  end

  p_rd_spacing_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> (since_rd_o >= t_ccd_i));
  p_wr_spacing_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> (since_wr_o >= t_ccd_i));
endmodule

// File: rtl/act_timing_guard.sv
module act_timing_guard
  import act_guard_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int CNT_W  = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [2:0]               cmd_i,
  input  logic [BANK_W-1:0]        bank_i,
  input  logic [ROW_W-1:0]         row_i,
  input  logic [CNT_W-1:0]         t_rcd_i,
  input  logic [CNT_W-1:0]         t_rc_i,
  input  logic [CNT_W-1:0]         t_rrd_i,
  input  logic [CNT_W-1:0]         t_faw_i,
  input  logic [CNT_W-1:0]         t_ccd_i,
  input  logic [CNT_W-1:0]         al_i,
  output logic                     allow_o,
  output logic                     viol_o,
  output logic [2:0]               viol_code_o,
  output logic [(1<<BANK_W)-1:0]   bank_open_o,
  output logic [ROW_W-1:0]         open_row_o
);
  localparam int NBANK = 1 << BANK_W;

  cmd_e                        cmd;
  err_e                        err;
  logic                        act_issue, rd_issue, wr_issue, pre_issue;
  logic [NBANK-1:0]            open;
  logic [NBANK-1:0][ROW_W-1:0] rows;
  logic [NBANK-1:0][CNT_W-1:0] since_act;
  logic [CNT_W-1:0]            since_any, oldest_age, since_rd, since_wr;
  logic                        oldest_valid;
  logic [CNT_W:0]              rcd_elapsed;
  logic [CNT_W-1:0]            since_cas;

  assign cmd         = cmd_e'(cmd_i);
  assign rcd_elapsed = {1'b0, since_act[bank_i]} + {1'b0, al_i};
  assign since_cas   = (cmd == CMD_RD) ? since_rd : since_wr;

  always_comb begin
    err = ERR_NONE;
    unique case (cmd)
      CMD_ACT: begin
        if (open[bank_i])                                err = ERR_OPEN;
        else if (since_act[bank_i] < t_rc_i)             err = ERR_RC;
        else if (since_any < t_rrd_i)                    err = ERR_RRD;
        else if (oldest_valid && oldest_age < t_faw_i)   err = ERR_FAW;
      end
      CMD_RD, CMD_WR: begin
        if (!open[bank_i])                               err = ERR_CLOSED;
        else if (rcd_elapsed < {1'b0, t_rcd_i})          err = ERR_RCD;
        else if (since_cas < t_ccd_i)                    err = ERR_CCD;
      end
      default: err = ERR_NONE;
    endcase
  end

  assign allow_o   = (err == ERR_NONE);
  assign act_issue = allow_o && (cmd == CMD_ACT);
  assign rd_issue  = allow_o && (cmd == CMD_RD);
  assign wr_issue  = allow_o && (cmd == CMD_WR);
  assign pre_issue = (cmd == CMD_PRE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_o      <= 1'b0;
      viol_code_o <= '0;
    end else begin
      viol_o      <= !allow_o;
      viol_code_o <= err;
    end
  end

  bank_tracker #(.BANK_W(BANK_W), .ROW_W(ROW_W), .CNT_W(CNT_W)) u_banks (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .act_set_i   (act_issue),
    .pre_set_i   (pre_issue),
    .bank_i      (bank_i),
    .row_i       (row_i),
    .open_o      (open),
    .row_o       (rows),
    .since_act_o (since_act)
  );

  act_window #(.CNT_W(CNT_W), .DEPTH(4)) u_window (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .act_i          (act_issue),
    .t_faw_i        (t_faw_i),
    .since_any_o    (since_any),
    .oldest_valid_o (oldest_valid),
    .oldest_age_o   (oldest_age)
  );

  cas_spacing #(.CNT_W(CNT_W)) u_cas (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (rd_issue),
    .wr_i       (wr_issue),
    .t_ccd_i    (t_ccd_i),
    .since_rd_o (since_rd),
    .since_wr_o (since_wr)
  );

  assign bank_open_o = open;
  assign open_row_o  = rows[bank_i];

  p_cas_needs_open_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_issue || wr_issue) |-> open[bank_i]);
  p_refuse_flags_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !allow_o |=> viol_o);
  p_allow_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    allow_o |=> (!viol_o && viol_code_o == 3'd0));
  p_nop_pre_free_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd0 || cmd_i == 3'd4) |-> allow_o);
endmodule

// File: tb/tb_act_timing_guard.sv
module tb_act_timing_guard;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  cmd_i = 3'd0;
  logic [2:0]  bank_i = '0;
  logic [13:0] row_i = '0;
  logic [7:0]  t_rcd_i = 8'd5, t_rc_i = 8'd12, t_rrd_i = 8'd2;
  logic [7:0]  t_faw_i = 8'd10, t_ccd_i = 8'd4, al_i = 8'd0;
  logic        allow_o, viol_o;
  logic [2:0]  viol_code_o;
  logic [7:0]  bank_open_o;
  logic [13:0] open_row_o;

  int tests = 0, fails = 0;

  typedef struct { logic v; logic [2:0] c; string tag; } exp_t;
  exp_t exp_q[$];

  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4;

  always #4 clk = ~clk;

  act_timing_guard dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd_i), .bank_i(bank_i), .row_i(row_i),
    .t_rcd_i(t_rcd_i), .t_rc_i(t_rc_i), .t_rrd_i(t_rrd_i), .t_faw_i(t_faw_i),
    .t_ccd_i(t_ccd_i), .al_i(al_i), .allow_o(allow_o), .viol_o(viol_o),
    .viol_code_o(viol_code_o), .bank_open_o(bank_open_o), .open_row_o(open_row_o)
  );

  task automatic check(input string tag, input int act_v, input int exp_v);
    tests++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
    end
  endtask

  // monitor: compares registered violation output one edge after each proposal
  always @(posedge clk) begin
    if (rst_ni && exp_q.size() > 0) begin
      exp_t e;
      #2;
      e = exp_q.pop_front();
      check({e.tag, " viol"}, viol_o, e.v);
      check({e.tag, " code"}, viol_code_o, e.c);
    end
  end

  task automatic propose(input logic [2:0] c, input int b, input logic [13:0] r,
                         input logic ok, input logic [2:0] code, input string tag);
    exp_t e;
    @(negedge clk);
    cmd_i = c; bank_i = 3'(b); row_i = r;
    #1;
    check({tag, " allow"}, allow_o, ok);
    e.v = !ok; e.c = code; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic do_reset;
    @(negedge clk);
    cmd_i = NOP;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    check("R10 reset banks closed", bank_open_o, 0);
    check("R10 reset viol low", viol_o, 0);

    // phase 1: AL = 0
    propose(ACT, 0, 14'h123, 1, 0, "R10 first act after reset");
    propose(ACT, 0, 14'h055, 0, 1, "R1 R11 act to open bank");
    check("R12 row kept after refused act", open_row_o, 14'h123);
    check("R9 bank state after refusal", bank_open_o, 8'h01);
    propose(ACT, 1, 14'h200, 1, 0, "R3 act at trrd");
    propose(RD, 0, 0, 0, 6, "R6 rd before trcd");
    propose(RD, 2, 0, 0, 5, "R5 rd to closed bank");
    propose(RD, 0, 0, 1, 0, "R6 rd at trcd");
    propose(WR, 0, 0, 1, 0, "R7 wr not delayed by rd");
    propose(RD, 1, 0, 0, 7, "R7 rd inside tccd");
    propose(WR, 1, 0, 0, 7, "R7 wr inside tccd");
    propose(RD, 1, 0, 1, 0, "R7 rd at tccd");
    propose(PRE, 0, 0, 1, 0, "R8 precharge open bank");
    propose(ACT, 0, 14'h077, 0, 2, "R2 act inside trc");
    check("R8 precharge closed bank", bank_open_o, 8'h02);
    propose(ACT, 0, 14'h077, 1, 0, "R2 act at trc");
    propose(NOP, 0, 0, 1, 0, "R13 nop allowed");
    check("R12 new row shown", open_row_o, 14'h077);
    propose(PRE, 5, 0, 1, 0, "R8 precharge closed bank allowed");
    propose(3'd6, 2, 0, 1, 0, "R13 unused code as nop");
    check("R8 R13 banks unchanged", bank_open_o, 8'h03);
    propose(NOP, 0, 0, 1, 0, "R9 idle");

    // phase 2: four-activate window
    do_reset;
    propose(ACT, 0, 1, 1, 0, "R4 act 1");
    propose(NOP, 0, 0, 1, 0, "R4 gap");
    propose(ACT, 1, 1, 1, 0, "R4 act 2");
    propose(NOP, 0, 0, 1, 0, "R4 gap");
    propose(ACT, 2, 1, 1, 0, "R4 act 3");
    propose(NOP, 0, 0, 1, 0, "R4 gap");
    propose(ACT, 3, 1, 1, 0, "R4 act 4");
    propose(NOP, 0, 0, 1, 0, "R4 gap");
    propose(ACT, 4, 1, 0, 4, "R4 fifth act age 8");
    propose(ACT, 4, 1, 0, 4, "R4 fifth act age 9");
    propose(ACT, 4, 1, 1, 0, "R4 fifth act at tfaw");
    propose(ACT, 5, 1, 0, 3, "R3 act inside trrd");
    check("R9 R4 open set", bank_open_o, 8'h1F);
    propose(NOP, 0, 0, 1, 0, "R9 idle");

    // phase 3: additive latency
    @(negedge clk); al_i = 8'd3;
    do_reset;
    #1;
    check("R10 reset clears banks", bank_open_o, 0);
    propose(ACT, 7, 14'h3FFF, 1, 0, "R6 act bank 7");
    propose(RD, 7, 0, 0, 6, "R6 rd with al below trcd");
    propose(WR, 7, 0, 1, 0, "R6 wr with al at trcd");
    propose(NOP, 7, 0, 1, 0, "R12 idle");
    check("R12 max row", open_row_o, 14'h3FFF);
    propose(NOP, 0, 0, 1, 0, "R9 idle");

    repeat (3) @(negedge clk);
    check("R9 queue drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule